// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running clock/calendar and raises an alarm when the time agrees with a stored setpoint. It holds two alarms, and both compare against the same time base. The time base supplies six BCD values: seconds, minutes, hours, day of week, date and month. A one-cycle `tick` strobe marks each advance of the one-second time base. An alarm is evaluated only in a cycle where `tick` is high, so it can fire at most once in any second.

Each alarm has its own write port. The port selects one of seven registers: one setpoint register for each of the six fields, plus one control register. The control register holds six per-field enables, a repeat bit and an arm bit. When an alarm fires it sets a sticky status flag, which the host polls and clears by writing a one to it. A one-shot alarm disarms itself after it fires. A repeating alarm stays armed and fires again each time its enabled fields match, so it works as a periodic event source. The setpoints are held in plain registers.

All pins are plain control and status signals; no stream interface is involved, so there is no back-pressure.

Top module: `cal_alarm_match`

## Requirements
- R1: While `rst_n` is low, every status flag, arm bit, repeat bit, field enable and setpoint is forced to zero.
- R2: An alarm fires when all of the following hold in the same cycle: `tick` is high, the alarm is armed, at least one field is enabled, and every enabled field equals the current time value. The alarm's `alarm_flag` bit is then set on the next clock edge. If any enabled field differs, the alarm does not fire.
- R3: A field whose enable bit is zero counts as matching, whatever its setpoint or the current time value.
- R4: An alarm with no field enabled never fires, even when it is armed and `tick` is high.
- R5: An alarm never fires in a cycle where `tick` is low, even if all its enabled fields match.
- R6: When the repeat bit is zero, the arm bit clears on the edge at which the alarm fires. A later match does not set the flag again.
- R7: When the repeat bit is one, the arm bit stays set after a fire. The alarm fires again on every later tick on which its fields match.
- R8: A status flag stays set until a cycle in which its `flag_clr` bit is high. A `flag_clr` bit that belongs to the other alarm has no effect on it.
- R9: If a fire and a clear of the same flag occur in the same cycle, the flag ends that cycle set.
- R10: The two alarms are independent. Writes, fires and clears on one alarm leave the other alarm's flag and arm bit unchanged.
- R11: An alarm whose arm bit is zero never fires.
- R12: The `cfg_sel` codes select these registers: 0 = seconds, 1 = minutes, 2 = hours, 3 = day of week, 4 = date, 5 = month, 6 = control, and 7 is ignored. In the control register, bits 5:0 are the field enables in the same order as the codes, bit 6 is repeat and bit 7 is arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe for each one-second advance of the time base |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_dow | input | 8 | Current day of week |
| now_date | input | 8 | Current date, BCD |
| now_month | input | 8 | Current month, BCD |
| cfg_we | input | 2 | Write strobe, one bit per alarm |
| cfg_sel | input | 6 | Register select, 3 bits per alarm (alarm 0 in bits 2:0) |
| cfg_data | input | 16 | Write data, 8 bits per alarm (alarm 0 in bits 7:0) |
| flag_clr | input | 2 | Write-one-to-clear strobe for the status flags |
| alarm_flag | output | 2 | Sticky status flags, one per alarm |
| alarm_armed | output | 2 | Current arm bit of each alarm |

## Verification
A new fire and the host's clear of the same status flag can land in the same cycle. The bench provokes this by raising `tick` together with `flag_clr` on a repeating alarm whose fields match. It then judges the flag one cycle later, where the flag must be set.

A second coincidence is a one-shot fire in the same cycle as an ordinary tick on the other alarm. This case shows that the auto-disarm of one alarm does not touch the other alarm's arm bit.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int SEL_W      = 3;
  localparam int SEL_CTRL   = 6;
  localparam int CTRL_RPT   = 6;
  localparam int CTRL_ARM   = 7;
  localparam int CTRL_W     = 8;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int FW = 8
) (
  input  logic [FW-1:0] now_f,
  input  logic [FW-1:0] set_f,
  input  logic          en,
  output logic          hit
);
  always_comb hit = !en || (now_f == set_f);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/alm_channel.sv
module alm_channel
  import alm_pkg::*;
#(
  parameter int FW = 8,
  localparam int VW = NUM_FIELDS * FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VW-1:0]    now_vec,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [FW-1:0]    data,
  output logic             fire,
  output logic             armed,
  output logic             rpt
);
  logic [VW-1:0]         setp_q;
  logic [NUM_FIELDS-1:0] en_q;
  logic [NUM_FIELDS-1:0] hit;
  logic                  rpt_q, arm_q;
  logic                  ctrl_wr;

  assign ctrl_wr = we && (sel == SEL_W'(SEL_CTRL));

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        setp_q[f*FW +: FW] <= '0;
      else if (we && sel == SEL_W'(f))
        setp_q[f*FW +: FW] <= data;
    end

    alm_field_cmp #(.FW(FW)) u_cmp (
      .now_f (now_vec[f*FW +: FW]),
      .set_f (setp_q[f*FW +: FW]),
      .en    (en_q[f]),
      .hit   (hit[f])
    );
  end

  assign fire = tick && arm_q && (|en_q) && (&hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      rpt_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= data[NUM_FIELDS-1:0];
      rpt_q <= data[CTRL_RPT];
      arm_q <= data[CTRL_ARM];
    end else if (fire && !rpt_q) begin
      arm_q <= 1'b0;
    end
  end

  assign armed = arm_q;
  assign rpt   = rpt_q;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import alm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int FW         = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [FW-1:0]               now_sec,
  input  logic [FW-1:0]               now_min,
  input  logic [FW-1:0]               now_hour,
  input  logic [FW-1:0]               now_dow,
  input  logic [FW-1:0]               now_date,
  input  logic [FW-1:0]               now_month,
  input  logic [NUM_ALARMS-1:0]       cfg_we,
  input  logic [NUM_ALARMS*SEL_W-1:0] cfg_sel,
  input  logic [NUM_ALARMS*FW-1:0]    cfg_data,
  input  logic [NUM_ALARMS-1:0]       flag_clr,
  output logic [NUM_ALARMS-1:0]       alarm_flag,
  output logic [NUM_ALARMS-1:0]       alarm_armed
);
  localparam int VW = NUM_FIELDS * FW;

  logic [VW-1:0]         now_vec;
  logic [NUM_ALARMS-1:0] fire_v;
  logic [NUM_ALARMS-1:0] rpt_v;

  assign now_vec = {now_month, now_date, now_dow, now_hour, now_min, now_sec};

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    alm_channel #(.FW(FW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .now_vec (now_vec),
      .we      (cfg_we[a]),
      .sel     (cfg_sel[a*SEL_W +: SEL_W]),
      .data    (cfg_data[a*FW +: FW]),
      .fire    (fire_v[a]),
      .armed   (alarm_armed[a]),
      .rpt     (rpt_v[a])
    );

    alm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fire_v[a]),
      .clr_i  (flag_clr[a]),
      .flag_o (alarm_flag[a])
    );
  end
endmodule

// File: rtl/alm_checker.sv
module alm_checker
  import alm_pkg::*;
#(
  parameter int NA = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [NA-1:0]       cfg_we,
  input logic [NA*SEL_W-1:0] cfg_sel,
  input logic [NA-1:0]       flag_clr,
  input logic [NA-1:0]       alarm_flag,
  input logic [NA-1:0]       alarm_armed,
  input logic [NA-1:0]       fire,
  input logic [NA-1:0]       rpt
);
  logic [NA-1:0] ctrl_wr;
  for (genvar i = 0; i < NA; i++) begin : g_chk
    assign ctrl_wr[i] = cfg_we[i] && (cfg_sel[i*SEL_W +: SEL_W] == SEL_W'(SEL_CTRL));

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (alarm_flag[i] == 1'b0 && alarm_armed[i] == 1'b0));

    // R5 and R11
    a_r5_fire_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |-> (tick && alarm_armed[i]));

    a_r5_flag_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag[i]) |-> $past(tick));

    // R8
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag[i] && !flag_clr[i]) |=> alarm_flag[i]);

    // R9
    a_r9_fire_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> alarm_flag[i]);

    // R6
    a_r6_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && !rpt[i] && !ctrl_wr[i]) |=> !alarm_armed[i]);

    // R7
    a_r7_repeat_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && rpt[i] && !ctrl_wr[i]) |=> alarm_armed[i]);
  end
endmodule

bind cal_alarm_match alm_checker #(.NA(NUM_ALARMS)) u_alm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .flag_clr    (flag_clr),
  .alarm_flag  (alarm_flag),
  .alarm_armed (alarm_armed),
  .fire        (fire_v),
  .rpt         (rpt_v)
);

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [7:0] now_dow = '0, now_date = '0, now_month = '0;
  logic [1:0] cfg_we = '0;
  logic [5:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic [1:0] flag_clr = '0;
  logic [1:0] alarm_flag, alarm_armed;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] flag;
    logic [1:0] armed;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  cal_alarm_match u_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_dow(now_dow), .now_date(now_date), .now_month(now_month),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .flag_clr(flag_clr), .alarm_flag(alarm_flag), .alarm_armed(alarm_armed)
  );

  // monitor: pops expected items and compares at the moment they are pushed
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (alarm_flag !== e.flag || alarm_armed !== e.armed) begin
          errors++;
          $display("FAIL %s: flag=%b armed=%b expected flag=%b armed=%b",
                   e.tag, alarm_flag, alarm_armed, e.flag, e.armed);
        end
      end
    end
  end

  task automatic expect_state(string tag, logic [1:0] f, logic [1:0] a);
    exp_t e;
    e.tag = tag; e.flag = f; e.armed = a;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic cfg(int ch, logic [2:0] sel, logic [7:0] data);
    @(negedge clk);
    cfg_we[ch] = 1'b1;
    cfg_sel[ch*3 +: 3] = sel;
    cfg_data[ch*8 +: 8] = data;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic do_tick(logic [1:0] clr);
    @(negedge clk);
    tick = 1'b1;
    flag_clr = clr;
    @(negedge clk);
    tick = 1'b0;
    flag_clr = '0;
  endtask

  task automatic do_clr(logic [1:0] clr);
    @(negedge clk);
    flag_clr = clr;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R1 during reset", 2'b00, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1 after reset", 2'b00, 2'b00);

    // alarm 0: sec 0x30, min 0x15, enables sec+min, arm, one-shot
    cfg(0, 3'd0, 8'h30);
    cfg(0, 3'd1, 8'h15);
    cfg(0, 3'd2, 8'h09);
    cfg(0, 3'd7, 8'hFF);        // R12 code 7 ignored
    expect_state("R12 code 7 ignored", 2'b00, 2'b00);
    cfg(0, 3'd6, 8'h83);
    expect_state("R12 control arm bit", 2'b00, 2'b01);

    now_sec = 8'h30; now_min = 8'h15; now_hour = 8'h22;
    now_dow = 8'h05; now_date = 8'h11; now_month = 8'h07;
    repeat (2) @(negedge clk);
    expect_state("R5 no tick no fire", 2'b00, 2'b01);

    now_min = 8'h16;
    do_tick(2'b00);
    expect_state("R2 enabled field differs", 2'b00, 2'b01);

    now_min = 8'h15;
    do_tick(2'b00);
    expect_state("R2 R3 R6 fire, hour disabled, disarm", 2'b01, 2'b00);

    do_clr(2'b10);
    expect_state("R8 R10 other clear bit ignored", 2'b01, 2'b00);
    do_clr(2'b01);
    expect_state("R8 clear", 2'b00, 2'b00);

    do_tick(2'b00);
    expect_state("R6 no refire after disarm", 2'b00, 2'b00);

    // R4: armed, no enables
    cfg(0, 3'd6, 8'h80);
    do_tick(2'b00);
    expect_state("R4 no field enabled", 2'b00, 2'b01);

    // R11: enables but not armed
    cfg(0, 3'd6, 8'h03);
    do_tick(2'b00);
    expect_state("R11 unarmed", 2'b00, 2'b00);

    // R7: alarm 1 day-of-week 3, repeat, arm
    cfg(1, 3'd3, 8'h03);
    cfg(1, 3'd6, 8'hC8);
    expect_state("R10 alarm1 armed only", 2'b00, 2'b10);
    now_dow = 8'h03;
    do_tick(2'b00);
    expect_state("R7 repeat first fire", 2'b10, 2'b10);
    do_clr(2'b10);
    expect_state("R7 cleared", 2'b00, 2'b10);
    now_sec = 8'h31;
    do_tick(2'b00);
    expect_state("R7 repeat second fire", 2'b10, 2'b10);

    // R9: fire and clear together
    do_tick(2'b10);
    expect_state("R9 fire beats clear", 2'b10, 2'b10);
    do_clr(2'b10);
    expect_state("R9 cleared afterwards", 2'b00, 2'b10);

    now_dow = 8'h04;
    do_tick(2'b00);
    expect_state("R2 dow mismatch", 2'b00, 2'b10);

    // date/month on alarm 0 while alarm 1 also fires (R10)
    cfg(0, 3'd4, 8'h28);
    cfg(0, 3'd5, 8'h12);
    cfg(0, 3'd6, 8'hB0);
    now_date = 8'h28; now_month = 8'h11; now_dow = 8'h03;
    do_tick(2'b00);
    expect_state("R2 month differs, R10 alarm1 fires", 2'b10, 2'b11);
    do_clr(2'b10);
    now_month = 8'h12;
    do_tick(2'b00);
    expect_state("R2 R10 both fire, only alarm0 disarms", 2'b11, 2'b10);

    rst_n = 1'b0;
    @(negedge clk);
    expect_state("R1 reset again", 2'b00, 2'b00);
    rst_n = 1'b1;
    do_tick(2'b00);
    expect_state("R1 setpoints cleared", 2'b00, 2'b00);

    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule